// File: doc/BRIEF.md
# Serial Flash Auto-Increment Word Program Engine

This block sits on the device side of a serial flash and handles the command traffic for programming the array one 16-bit word at a time. It takes the SPI pins (serial clock, serial in, active-low chip select) in mode 0 or mode 3 and samples them with the system clock. It keeps a write-enable latch, an auto-increment mode flag and a busy flag. It also drives the serial output, either with status byte data or with a ready/busy level. Each accepted word becomes two byte-write transfers on a valid/ready port that feeds a behavioural array model.

The first program command carries the opcode, a 24-bit address and two data bytes. After that, the engine holds the word pointer, and each later program command carries only the opcode and two data bytes. The engine leaves auto-increment mode by itself once the last byte below the protected region has been written. The protected region starts at the `prot_start` input and runs to the top of the address space. The program time is set by the `prog_cycles` input.

The write port follows valid/ready rules. Once `wr_valid` is high, it stays high with `wr_addr` and `wr_data` unchanged until a cycle in which `wr_ready` is high. The consumer may hold `wr_ready` low for any number of cycles, and the busy flag stays set until both bytes of the word have been accepted.

Top module: `aai_flash_prog`

## Requirements
- R1: Opcode 06h sets the write-enable latch when not in auto-increment mode. Opcode 05h returns the status byte MSB first, starting right after the opcode, and repeats it for each further 8 clocks while chip select stays low. Status bit 0 is busy, bit 1 is the write-enable latch, bit 6 is auto-increment mode, and the other bits are 0.
- R2: Opcode ADh with the latch set, a 24-bit address and two data bytes, all MSB first, writes the first data byte to the address with bit 0 forced to 0 and the second to the same address with bit 0 at 1. The command enters auto-increment mode (status bit 6).
- R3: A first ADh command is ignored if the latch is clear, or if the upper byte of the addressed word lies at or above `prot_start`. No byte is ever written at or above `prot_start`.
- R4: A command acts only when chip select rises after all of its bits. A command cut short by chip select rising before its last bit has no effect.
- R5: Status bit 0 is set from the accepting chip select rise until at least `prog_cycles` clocks have passed (a value of 0 counts as 1) and both byte writes have been accepted.
- R6: In auto-increment mode, ADh is followed by just two data bytes, which are written to the two addresses following the previous word.
- R7: In auto-increment mode, only ADh, 05h, 04h, 70h and 80h are honoured. While busy, only 05h is honoured. Any other command is ignored.
- R8: Opcode 04h clears both the write-enable latch and auto-increment mode.
- R9: Addresses never wrap. When a word ending at `prot_start`-1 (or at the top address) finishes programming, auto-increment mode and the latch are both cleared.
- R10: After opcode 70h, while in auto-increment mode with chip select low, SO is driven with 1 for ready and 0 for busy. Opcode 80h restores status data on SO. SO is undriven (`so_oe` low) whenever chip select is high.
- R11: On the write port, `wr_valid` stays high with stable `wr_addr` and `wr_data` until `wr_ready`. The two bytes of a word go out in order, even address first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also used to sample the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | SPI serial clock |
| cs_n | input | 1 | SPI chip select, active low |
| si | input | 1 | SPI serial data in |
| so | output | 1 | SPI serial data out value |
| so_oe | output | 1 | Output enable for SO; low means high impedance |
| prot_start | input | 24 | First protected byte address (nonzero) |
| prog_cycles | input | 16 | Program time per word, in clocks |
| wr_valid | output | 1 | Byte write request valid |
| wr_ready | input | 1 | Array accepts the byte write |
| wr_addr | output | 24 | Byte address of the write |
| wr_data | output | 8 | Byte value of the write |

## Verification
The program command is driven in three forms: a full first command with an odd starting address, a two-byte continuation, and a truncated first command. Together these separate address alignment, pointer advance and completion-gated execution. Rejected variants cover a clear latch, a protected start, an unknown opcode in auto-increment mode and a write-disable sent while busy, each of which must leave status and the write port unchanged. A run ending just below `prot_start` shows the automatic exit. Probes of the ready/busy pin during and after programming, done with a back-pressured write port, show that the busy level tracks both the timer and the pending array writes.

// File: rtl/aai_flash_pkg.sv
package aai_flash_pkg;
  localparam int ADDR_W = 24;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_AAI   = 8'hAD;
  localparam logic [7:0] OP_RBON  = 8'h70;
  localparam logic [7:0] OP_RBOFF = 8'h80;

  localparam int ST_BUSY = 0;
  localparam int ST_WEL  = 1;
  localparam int ST_AAI  = 6;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [7:0]        d0;
    logic [7:0]        d1;
  } word_job_t;
endpackage

// File: rtl/aai_spi_rx.sv
module aai_spi_rx #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck,
  input  logic             cs_n,
  input  logic             si,
  output logic             cs_low,
  output logic             cs_rise,
  output logic             sck_fall,
  output logic             byte_vld,
  output logic [7:0]       byte_val,
  output logic [IDX_W-1:0] byte_idx,
  output logic [IDX_W-1:0] nbytes
);
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

  logic s_sck, s_sck_q, s_cs, s_cs_q, s_si;
  logic [2:0] bitc;
  logic [6:0] sh;
  logic sck_rise;

  assign cs_low   = ~s_cs;
  assign cs_rise  = s_cs & ~s_cs_q;
  assign sck_rise = s_sck & ~s_sck_q & ~s_cs;
  assign sck_fall = ~s_sck & s_sck_q & ~s_cs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_sck   <= 1'b0;
      s_sck_q <= 1'b0;
      s_cs    <= 1'b1;
      s_cs_q  <= 1'b1;
      s_si    <= 1'b0;
    end else begin
      s_sck   <= sck;
      s_sck_q <= s_sck;
      s_cs    <= cs_n;
      s_cs_q  <= s_cs;
      s_si    <= si;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitc     <= '0;
      sh       <= '0;
      byte_vld <= 1'b0;
      byte_val <= '0;
      byte_idx <= '0;
      nbytes   <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (s_cs) begin
        bitc   <= '0;
        nbytes <= '0;
      end else if (sck_rise) begin
        sh   <= {sh[5:0], s_si};
        bitc <= bitc + 3'd1;
        if (bitc == 3'd7) begin
          byte_vld <= 1'b1;
          byte_val <= {sh, s_si};
          byte_idx <= nbytes;
          if (nbytes != IDX_MAX) nbytes <= nbytes + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/aai_cmd_ctrl.sv
module aai_cmd_ctrl
  import aai_flash_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [7:0]        byte_val,
  input  logic [IDX_W-1:0]  byte_idx,
  input  logic [IDX_W-1:0]  nbytes,
  input  logic              cs_rise,
  input  logic              busy,
  input  logic              prog_done,
  input  logic [ADDR_W-1:0] prot_start,
  output logic              wel,
  output logic              aai,
  output logic              rb_en,
  output logic              rd_start,
  output logic              start,
  output word_job_t         job
);
  localparam logic [IDX_W-1:0] N_OP   = IDX_W'(1);
  localparam logic [IDX_W-1:0] N_CONT = IDX_W'(3);
  localparam logic [IDX_W-1:0] N_FULL = IDX_W'(6);

  logic [7:0]        opcode;
  logic              cont;
  logic [ADDR_W-1:0] addr_r, next_word, first_word;
  logic [7:0]        d0, d1;
  logic              last_flag;
  logic              busy_g;
  logic              first_ok;

  assign busy_g     = busy | prog_done;
  assign first_word = {addr_r[ADDR_W-1:1], 1'b0};
  assign first_ok   = wel && ({addr_r[ADDR_W-1:1], 1'b1} < prot_start);
  assign rd_start   = byte_vld && (byte_idx == '0) && (byte_val == OP_RDSR);

  function automatic logic ends_run(input logic [ADDR_W-1:0] w,
                                    input logic [ADDR_W-1:0] lim);
    logic [ADDR_W:0] hi;
    hi = {1'b0, w} + (ADDR_W+1)'(3);
    return hi >= {1'b0, lim};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode    <= '0;
      cont      <= 1'b0;
      addr_r    <= '0;
      d0        <= '0;
      d1        <= '0;
      next_word <= '0;
      last_flag <= 1'b0;
      wel       <= 1'b0;
      aai       <= 1'b0;
      rb_en     <= 1'b0;
      start     <= 1'b0;
      job       <= '0;
    end else begin
      start <= 1'b0;
      if (byte_vld) begin
        if (byte_idx == '0) begin
          opcode <= byte_val;
          cont   <= aai;
        end else if (!cont && byte_idx <= IDX_W'(3)) begin
          addr_r <= {addr_r[ADDR_W-9:0], byte_val};
        end
        if ((cont && byte_idx == IDX_W'(1)) || (!cont && byte_idx == IDX_W'(4))) d0 <= byte_val;
        if ((cont && byte_idx == IDX_W'(2)) || (!cont && byte_idx == IDX_W'(5))) d1 <= byte_val;
      end
      if (prog_done && last_flag) begin
        aai <= 1'b0;
        wel <= 1'b0;
      end
      if (cs_rise && !busy_g && nbytes >= N_OP) begin
        case (opcode)
          OP_WREN:  if (!aai) wel <= 1'b1;
          OP_WRDI:  begin wel <= 1'b0; aai <= 1'b0; end
          OP_RBON:  rb_en <= 1'b1;
          OP_RBOFF: rb_en <= 1'b0;
          OP_AAI: begin
            if (aai && cont && nbytes >= N_CONT) begin
              start     <= 1'b1;
              job       <= '{addr: next_word, d0: d0, d1: d1};
              next_word <= next_word + ADDR_W'(2);
              last_flag <= ends_run(next_word, prot_start);
            end else if (!aai && !cont && nbytes >= N_FULL && first_ok) begin
              start     <= 1'b1;
              aai       <= 1'b1;
              job       <= '{addr: first_word, d0: d0, d1: d1};
              next_word <= first_word + ADDR_W'(2);
              last_flag <= ends_run(first_word, prot_start);
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/aai_prog_unit.sv
module aai_prog_unit
  import aai_flash_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  word_job_t         job,
  input  logic [CNT_W-1:0]  cycles,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              busy,
  output logic              done
);
  logic [CNT_W-1:0] cnt;
  logic [1:0]       phase;
  word_job_t        job_r;

  assign wr_valid = busy && (phase != 2'd2);
  assign wr_addr  = (phase == 2'd0) ? job_r.addr : {job_r.addr[ADDR_W-1:1], 1'b1};
  assign wr_data  = (phase == 2'd0) ? job_r.d0 : job_r.d1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 2'd2;
      job_r <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy  <= 1'b1;
        phase <= 2'd0;
        job_r <= job;
        cnt   <= (cycles == '0) ? CNT_W'(1) : cycles;
      end else if (busy) begin
        if (cnt != '0) cnt <= cnt - 1'b1;
        if (wr_valid && wr_ready) phase <= phase + 2'd1;
        if (cnt == '0 && phase == 2'd2) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/aai_so_drv.sv
module aai_so_drv (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_low,
  input  logic       sck_fall,
  input  logic       rd_start,
  input  logic [7:0] status,
  input  logic       rb_mode,
  input  logic       busy,
  output logic       so,
  output logic       so_oe
);
  logic       rd_act;
  logic [2:0] bpos;
  logic [6:0] sh;
  logic       so_q;

  assign so    = rb_mode ? ~busy : so_q;
  assign so_oe = cs_low & (rb_mode | rd_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act <= 1'b0;
      bpos   <= '0;
      sh     <= '0;
      so_q   <= 1'b0;
    end else if (!cs_low) begin
      rd_act <= 1'b0;
      bpos   <= '0;
    end else begin
      if (rd_start) rd_act <= 1'b1;
      if (sck_fall && rd_act) begin
        bpos <= bpos + 3'd1;
        if (bpos == 3'd0) begin
          so_q <= status[7];
          sh   <= status[6:0];
        end else begin
          so_q <= sh[6];
          sh   <= {sh[5:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/aai_flash_prog.sv
module aai_flash_prog
  import aai_flash_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  output logic              so,
  output logic              so_oe,
  input  logic [ADDR_W-1:0] prot_start,
  input  logic [CNT_W-1:0]  prog_cycles,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  logic             cs_low, cs_rise, sck_fall, byte_vld;
  logic [7:0]       byte_val;
  logic [IDX_W-1:0] byte_idx, nbytes;
  logic             wel, aai, rb_en, rd_start, start, busy, done;
  word_job_t        job;
  logic [7:0]       status;

  always_comb begin
    status          = '0;
    status[ST_BUSY] = busy;
    status[ST_WEL]  = wel;
    status[ST_AAI]  = aai;
  end

  aai_spi_rx #(.IDX_W(IDX_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .cs_low(cs_low), .cs_rise(cs_rise), .sck_fall(sck_fall),
    .byte_vld(byte_vld), .byte_val(byte_val), .byte_idx(byte_idx), .nbytes(nbytes)
  );

  aai_cmd_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_val(byte_val),
    .byte_idx(byte_idx), .nbytes(nbytes), .cs_rise(cs_rise), .busy(busy),
    .prog_done(done), .prot_start(prot_start), .wel(wel), .aai(aai),
    .rb_en(rb_en), .rd_start(rd_start), .start(start), .job(job)
  );

  aai_prog_unit #(.CNT_W(CNT_W)) u_prog (
    .clk(clk), .rst_n(rst_n), .start(start), .job(job), .cycles(prog_cycles),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done)
  );

  aai_so_drv u_so (
    .clk(clk), .rst_n(rst_n), .cs_low(cs_low), .sck_fall(sck_fall),
    .rd_start(rd_start), .status(status), .rb_mode(rb_en & aai), .busy(busy),
    .so(so), .so_oe(so_oe)
  );
endmodule

// File: rtl/aai_flash_sva.sv
module aai_flash_sva #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          so_oe,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic [AW-1:0] prot_start,
  input logic          busy,
  input logic          wel,
  input logic          aai
);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  p_unprot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_addr < prot_start);

  p_wr_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> busy);

  p_aai_wel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    aai |-> wel);

  p_so_float_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) |-> !so_oe);
endmodule

bind aai_flash_prog aai_flash_sva #(.AW(24)) u_sva (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so_oe(so_oe), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .prot_start(prot_start), .busy(busy), .wel(wel), .aai(aai)
);

// File: tb/aai_flash_prog_bench.sv
module aai_flash_prog_bench;
  localparam int H = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic        so, so_oe;
  logic [23:0] prot_start = 24'h000100;
  logic [15:0] prog_cycles = 16'd20;
  logic        wr_valid, wr_ready = 1'b0;
  logic [23:0] wr_addr;
  logic [7:0]  wr_data;

  int n_chk = 0, n_fail = 0, rdy_cnt = 0;
  logic [31:0] exp_q[$];
  logic        hold_prev = 1'b0;
  logic [31:0] prev_wr;

  always #5 clk = ~clk;

  aai_flash_prog u_aai_flash_prog (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .so(so), .so_oe(so_oe),
    .prot_start(prot_start), .prog_cycles(prog_cycles), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference write stream: compared on every clock
  always @(negedge clk) begin
    rdy_cnt++;
    wr_ready = (rdy_cnt % 3) != 2;
    if (rst_n) begin
      if (hold_prev) begin
        chk("R11 hold valid", int'(wr_valid), 1);
        chk("R11 hold payload", int'({wr_addr, wr_data}), int'(prev_wr));
      end
      if (wr_valid && wr_ready) begin
        if (exp_q.size() == 0) chk("R3 unexpected write", int'({wr_addr, wr_data}), 0);
        else chk("R2 R6 R11 write", int'({wr_addr, wr_data}), int'(exp_q.pop_front()));
      end
      hold_prev = wr_valid && !wr_ready;
      prev_wr   = {wr_addr, wr_data};
    end
  end

  task automatic hw();
    repeat (H) @(negedge clk);
  endtask

  task automatic spi_cmd(input logic [63:0] v, input int nbits);
    cs_n = 1'b0;
    hw();
    for (int i = nbits - 1; i >= 0; i--) begin
      si = v[i];
      hw();
      sck = 1'b1;
      hw();
      sck = 1'b0;
    end
    hw();
    cs_n = 1'b1;
    hw();
    hw();
  endtask

  task automatic rd_status(input int nb, output logic [15:0] val);
    logic [7:0] op;
    op  = 8'h05;
    val = '0;
    cs_n = 1'b0;
    hw();
    for (int i = 7; i >= 0; i--) begin
      si = op[i];
      hw();
      sck = 1'b1;
      hw();
      sck = 1'b0;
    end
    for (int k = 0; k < nb * 8; k++) begin
      si = 1'b0;
      hw();
      val = {val[14:0], so};
      sck = 1'b1;
      hw();
      sck = 1'b0;
    end
    hw();
    cs_n = 1'b1;
    hw();
    hw();
  endtask

  task automatic expect_status(input string req, input int exp);
    logic [15:0] v;
    rd_status(1, v);
    chk(req, int'(v[7:0]), exp);
  endtask

  task automatic rb_probe(output logic oe, output logic lvl, output logic oe_after);
    cs_n = 1'b0;
    hw();
    oe  = so_oe;
    lvl = so;
    cs_n = 1'b1;
    hw();
    oe_after = so_oe;
    hw();
  endtask

  task automatic push(input logic [23:0] a, input logic [7:0] d);
    exp_q.push_back({a, d});
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    logic oe, lvl, oe_after;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    chk("R10 reset so_oe", int'(so_oe), 0);
    chk("R11 reset wr_valid", int'(wr_valid), 0);
    expect_status("R1 reset status", 8'h00);

    // R3: program without write enable
    spi_cmd({8'hAD, 24'h000010, 8'h12, 8'h34}, 48);
    repeat (60) @(negedge clk);
    expect_status("R3 no latch", 8'h00);

    // R1: write enable, repeated status byte
    spi_cmd(64'h06, 8);
    rd_status(2, v);
    chk("R1 status byte 1", int'(v[15:8]), 8'h02);
    chk("R1 status byte 2", int'(v[7:0]), 8'h02);

    // R3: protected start address
    spi_cmd({8'hAD, 24'h000101, 8'h12, 8'h34}, 48);
    repeat (60) @(negedge clk);
    expect_status("R3 protected", 8'h02);

    // R4: truncated first command
    spi_cmd({8'hAD, 24'h000010, 8'h12}, 40);
    repeat (60) @(negedge clk);
    expect_status("R4 truncated", 8'h02);

    // R2 R5: first word at odd address, long program time
    prog_cycles = 16'd300;
    push(24'h0000F8, 8'hA5);
    push(24'h0000F9, 8'h3C);
    spi_cmd({8'hAD, 24'h0000F9, 8'hA5, 8'h3C}, 48);
    expect_status("R5 busy during program", 8'h43);
    repeat (400) @(negedge clk);
    expect_status("R2 auto mode entered", 8'h42);
    chk("R2 writes drained", exp_q.size(), 0);

    // R7: unknown opcode in auto mode
    prog_cycles = 16'd20;
    spi_cmd(64'h9F, 8);
    expect_status("R7 unknown opcode ignored", 8'h42);

    // R6: continuation word
    push(24'h0000FA, 8'h11);
    push(24'h0000FB, 8'h22);
    spi_cmd({8'hAD, 8'h11, 8'h22}, 24);
    repeat (100) @(negedge clk);
    expect_status("R6 continuation", 8'h42);
    chk("R6 writes drained", exp_q.size(), 0);

    // R8: write disable
    spi_cmd(64'h04, 8);
    expect_status("R8 write disable", 8'h00);

    // R10: ready/busy level on SO
    spi_cmd(64'h70, 8);
    spi_cmd(64'h06, 8);
    prog_cycles = 16'd300;
    push(24'h0000FC, 8'h33);
    push(24'h0000FD, 8'h44);
    spi_cmd({8'hAD, 24'h0000FC, 8'h33, 8'h44}, 48);
    rb_probe(oe, lvl, oe_after);
    chk("R10 oe while busy", int'(oe), 1);
    chk("R10 level busy", int'(lvl), 0);
    chk("R10 float after cs high", int'(oe_after), 0);
    repeat (400) @(negedge clk);
    rb_probe(oe, lvl, oe_after);
    chk("R10 oe when ready", int'(oe), 1);
    chk("R10 level ready", int'(lvl), 1);
    spi_cmd(64'h80, 8);
    expect_status("R10 status data restored", 8'h42);

    // R9: last word below protected region ends auto mode
    prog_cycles = 16'd20;
    push(24'h0000FE, 8'h55);
    push(24'h0000FF, 8'h66);
    spi_cmd({8'hAD, 8'h55, 8'h66}, 24);
    repeat (100) @(negedge clk);
    expect_status("R9 exit at top", 8'h00);
    spi_cmd({8'hAD, 8'h77, 8'h88}, 24);
    repeat (100) @(negedge clk);
    expect_status("R9 no wrap", 8'h00);
    chk("R9 no extra writes", exp_q.size(), 0);

    // R7: write disable while busy is ignored
    spi_cmd(64'h06, 8);
    prog_cycles = 16'd300;
    push(24'h000010, 8'h01);
    push(24'h000011, 8'h02);
    spi_cmd({8'hAD, 24'h000010, 8'h01, 8'h02}, 48);
    spi_cmd(64'h04, 8);
    repeat (400) @(negedge clk);
    expect_status("R7 busy ignores disable", 8'h42);
    spi_cmd(64'h04, 8);
    expect_status("R8 disable after busy", 8'h00);
    chk("R11 all writes seen", exp_q.size(), 0);

    finish_run();
  end
endmodule